// File: doc/BRIEF.md
# Clock Register Window with Coherent Snapshot

This block places eight calendar registers in the highest eight byte addresses of a 32K x 8 address space. It sits between a synchronous byte bus and an external calendar counter. The bus has an address, write data, read data, a read strobe and a write strobe. Every other address passes straight through to a RAM port. The block keeps its own visible copy of the time, separate from the live counter values. On each counter tick, the visible copy is refreshed from the counters in a single cycle.

Two control bits sit in the century byte. The freeze bit stops the refresh, so software can read a snapshot that does not change under it. The set bit also stops the refresh, so software can write a new time into the visible registers. Clearing the set bit hands the visible values to the counters as a one-cycle load. While the copy is held for either reason, the counters keep running.

The block also holds two further control bits: a stop request for the oscillator in the seconds byte and a test-output enable in the day byte. The top bit of the day byte is read-only and reflects the battery status input.

Top module: `rtc_regwin`

## Requirements
- R1: An access is a clock access when all address bits above bit 2 are 1, that is, offsets 0 to 7 at addresses 0x7FF8 to 0x7FFF. Any other address drives `ram_wr`/`ram_rd` with `ram_addr` equal to the bus address and `ram_wdata` equal to the bus data. A clock access never asserts `ram_wr` or `ram_rd`.
- R2: Read data appears on `bus_rdata` one clock after the cycle in which `bus_rd` is high. For RAM addresses it is the value returned on `ram_rdata`.
- R3: When both control bits are 0, a `tick` copies all eight live bytes into the visible registers in one cycle.
- R4: While the freeze bit (century byte, bit 6) is 1, ticks leave the visible registers unchanged.
- R5: While the set bit (century byte, bit 7) is 1, ticks leave the visible registers unchanged, and bus writes are stored in the visible registers.
- R6: A write to offset 0 that clears a set bit of 1 raises `load_valid` for exactly one cycle, starting the cycle after the write. In that cycle `load_time` holds the visible bytes, with offset n in bits 8n+7 to 8n.
- R7: Once both control bits are 0 again, the next tick refreshes every visible register from the live values.
- R8: Bit 7 of the day byte (offset 4) reads as `batt_ok` and cannot be written.
- R9: Bits with no function are dropped on writes and on refresh, and they read as 0. The kept bits per offset are: 0 bits 5:0, 1 bits 6:0, 2 bits 6:0, 3 bits 5:0, 4 bits 2:0, 5 bits 5:0, 6 bits 4:0, 7 bits 7:0.
- R10: The set and freeze bits read back at offset 0. The oscillator stop bit (offset 1, bit 7) reads back and drives `osc_stop`. The test-output bit (offset 4, bit 6) reads back and drives `freq_test`.
- R11: After reset, all visible registers and control bits are 0 and `load_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 15 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, one cycle after the strobe |
| ram_addr | output | 15 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_wr | output | 1 | RAM write strobe |
| ram_rd | output | 1 | RAM read strobe |
| ram_rdata | input | 8 | RAM read data, registered by the RAM |
| tick | input | 1 | Counter advanced this cycle |
| live_time | input | 64 | Live counter bytes, offset n in bits 8n+7:8n |
| batt_ok | input | 1 | Battery status |
| load_valid | output | 1 | One-cycle pulse to load the counters |
| load_time | output | 64 | Values to load, same packing as live_time |
| osc_stop | output | 1 | Oscillator stop request |
| freq_test | output | 1 | Test-output enable |

## Verification
The bench fills the unused bits of the live bytes with 1s and writes all-ones patterns. A design that masked the wrong fields would then leak stray bits into reads. It ticks the counter while the freeze bit is set and again while the set bit is set. A design that kept refreshing would return the newer seconds value instead of the snapshot or the value software wrote. It checks the load pulse in the exact cycle after the set bit clears and again one cycle later. A late, missing or stretched pulse, or one carrying stale bytes, is caught. It reads address 0x7FF7, the last RAM byte, and writes 0x7FF8, the first clock byte, to catch an off-by-one decode that would send clock traffic to RAM or the reverse.

// File: rtl/rtc_regwin.sv
module rtc_regwin #(
  parameter int ADDR_W = 15,
  parameter int NREG   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [7:0]          bus_wdata,
  input  logic                bus_wr,
  input  logic                bus_rd,
  output logic [7:0]          bus_rdata,
  output logic [ADDR_W-1:0]   ram_addr,
  output logic [7:0]          ram_wdata,
  output logic                ram_wr,
  output logic                ram_rd,
  input  logic [7:0]          ram_rdata,
  input  logic                tick,
  input  logic [8*NREG-1:0]   live_time,
  input  logic                batt_ok,
  output logic                load_valid,
  output logic [8*NREG-1:0]   load_time,
  output logic                osc_stop,
  output logic                freq_test
);
  localparam int OFF_W = $clog2(NREG);

  logic [7:0]       vis [NREG];
  logic             set_q, frz_q, osc_q, ft_q, load_q, rclk_q;
  logic [7:0]       rdat_q, rd_mux;
  logic             is_clk;
  logic [OFF_W-1:0] off;

  function automatic logic [7:0] keep_mask(input logic [OFF_W-1:0] o);
    case (o)
      0, 3, 5: keep_mask = 8'h3F;
      1, 2:    keep_mask = 8'h7F;
      4:       keep_mask = 8'h07;
      6:       keep_mask = 8'h1F;
      default: keep_mask = 8'hFF;
    endcase
  endfunction

  assign is_clk    = &bus_addr[ADDR_W-1:OFF_W];
  assign off       = bus_addr[OFF_W-1:0];
  assign ram_addr  = bus_addr;
  assign ram_wdata = bus_wdata;
  assign ram_wr    = bus_wr & ~is_clk;
  assign ram_rd    = bus_rd & ~is_clk;
  assign bus_rdata = rclk_q ? rdat_q : ram_rdata;
  assign load_valid = load_q;
  assign osc_stop  = osc_q;
  assign freq_test = ft_q;

  for (genvar g = 0; g < NREG; g++) begin : g_pack
    assign load_time[8*g +: 8] = vis[g];
  end

  always_comb begin
    case (off)
      0:       rd_mux = {set_q, frz_q, vis[0][5:0]};
      1:       rd_mux = {osc_q, vis[1][6:0]};
      4:       rd_mux = {batt_ok, ft_q, 3'b000, vis[4][2:0]};
      default: rd_mux = vis[off];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) vis[i] <= '0;
      set_q  <= 1'b0;
      frz_q  <= 1'b0;
      osc_q  <= 1'b0;
      ft_q   <= 1'b0;
      load_q <= 1'b0;
      rclk_q <= 1'b0;
      rdat_q <= '0;
    end else begin
      load_q <= 1'b0;
      if (bus_wr && is_clk) begin
        vis[off] <= bus_wdata & keep_mask(off);
        case (off)
          0: begin
            set_q  <= bus_wdata[7];
            frz_q  <= bus_wdata[6];
            load_q <= set_q & ~bus_wdata[7];
          end
          1: osc_q <= bus_wdata[7];
          4: ft_q  <= bus_wdata[6];
          default: ;
        endcase
      end else if (tick && !set_q && !frz_q && !load_q) begin
        for (int i = 0; i < NREG; i++)
          vis[i] <= live_time[8*i +: 8] & keep_mask(OFF_W'(i));
      end
      if (bus_rd) begin
        rclk_q <= is_clk;
        rdat_q <= rd_mux;
      end
    end
  end
endmodule

// File: rtl/rtc_regwin_chk.sv
module rtc_regwin_chk #(
  parameter int ADDR_W = 15,
  parameter int NREG   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_rdata,
  input logic              ram_wr,
  input logic              ram_rd,
  input logic              load_valid,
  input logic              set_q,
  input logic              frz_q,
  input logic [8*NREG-1:0] vis_flat
);
  localparam int OFF_W = $clog2(NREG);
  logic clk_acc;
  assign clk_acc = &bus_addr[ADDR_W-1:OFF_W];

  AST_CLK_NOT_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) && clk_acc |-> !ram_wr && !ram_rd); // R1
  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    frz_q && !bus_wr |=> $stable(vis_flat)); // R4
  AST_SET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    set_q && !bus_wr |=> $stable(vis_flat)); // R5
  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |=> !load_valid); // R6
  AST_LOAD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |-> $past(bus_wr && clk_acc && bus_addr[OFF_W-1:0] == '0 && !bus_wdata[7])); // R6
  AST_MONTH_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && clk_acc && bus_addr[OFF_W-1:0] == OFF_W'(6)) |-> bus_rdata[7:5] == 3'b000); // R9
endmodule

bind rtc_regwin rtc_regwin_chk #(.ADDR_W(ADDR_W), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .ram_wr(ram_wr),
  .ram_rd(ram_rd), .load_valid(load_valid), .set_q(set_q), .frz_q(frz_q),
  .vis_flat(load_time)
);

// File: tb/rtc_regwin_test.sv
module rtc_regwin_test;
  logic        clk = 0, rst_n = 0;
  logic [14:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 0, bus_rd = 0, tick = 0, batt_ok = 1;
  logic [7:0]  bus_rdata, ram_wdata, ram_rdata;
  logic [14:0] ram_addr;
  logic        ram_wr, ram_rd, load_valid, osc_stop, freq_test;
  logic [63:0] live_time = '0, load_time;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] q_exp[$];
  string      q_tag[$];

  always #5 clk = ~clk;

  rtc_regwin uut (.*);

  always_ff @(posedge clk) if (ram_rd) ram_rdata <= ram_addr[7:0] ^ 8'h5A;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [14:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    bus_addr = a; bus_rd = 1;
    #1 check({tag, " ram_rd"}, 64'(ram_rd), 64'(!(&a[14:3])));
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    #1 check("R1 ram_wr", 64'(ram_wr), 64'(!(&a[14:3])));
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic pulse_tick;
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  initial forever begin
    @(posedge clk);
    if (bus_rd) begin
      @(negedge clk);
      check(q_tag.pop_front(), 64'(bus_rdata), 64'(q_exp.pop_front()));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R11 load_valid reset", 64'(load_valid), 0);
    rd(15'h7FF9, 8'h00, "R11 seconds reset");
    rd(15'h7FF8, 8'h00, "R11 century reset");
    rd(15'h7FFC, 8'h80, "R8 day reset batt");

    live_time = {8'h99, 8'hF2, 8'h31, 8'hFF, 8'h23, 8'hD9, 8'hC5, 8'hE0};
    pulse_tick();
    rd(15'h7FF9, 8'h45, "R3 seconds refresh");
    rd(15'h7FFC, 8'h87, "R9 day masked");
    rd(15'h7FFE, 8'h12, "R9 month masked");
    rd(15'h7FFF, 8'h99, "R3 year refresh");
    rd(15'h7FF8, 8'h20, "R3 century refresh");

    wr(15'h7FF8, 8'h60);
    live_time[15:8] = 8'h10; live_time[63:56] = 8'h00;
    pulse_tick();
    rd(15'h7FF9, 8'h45, "R4 frozen seconds");
    rd(15'h7FF8, 8'h60, "R10 freeze bit readback");

    wr(15'h7FF8, 8'h20);
    pulse_tick();
    rd(15'h7FF9, 8'h10, "R7 seconds after unfreeze");
    rd(15'h7FFF, 8'h00, "R7 year after unfreeze");

    wr(15'h7FF8, 8'hA1);
    wr(15'h7FF9, 8'h30);
    wr(15'h7FFF, 8'h24);
    wr(15'h7FFE, 8'hE9);
    pulse_tick();
    rd(15'h7FF9, 8'h30, "R5 seconds held under set");
    rd(15'h7FFE, 8'h09, "R9 month write masked");
    batt_ok = 0;
    wr(15'h7FFC, 8'hC5);
    rd(15'h7FFC, 8'h45, "R8 batt flag not writable");
    check("R10 freq_test", 64'(freq_test), 1);
    batt_ok = 1;
    rd(15'h7FF8, 8'hA1, "R10 set bit readback");

    wr(15'h7FF8, 8'h21);
    check("R6 load_valid pulse", 64'(load_valid), 1);
    check("R6 load seconds", 64'(load_time[15:8]), 64'h30);
    check("R6 load year", 64'(load_time[63:56]), 64'h24);
    check("R6 load century", 64'(load_time[7:0]), 64'h21);
    check("R6 load month", 64'(load_time[55:48]), 64'h09);
    @(negedge clk);
    check("R6 load_valid single", 64'(load_valid), 0);
    pulse_tick();
    rd(15'h7FF9, 8'h10, "R7 seconds after set cleared");

    wr(15'h7FF9, 8'h92);
    check("R10 osc_stop", 64'(osc_stop), 1);
    rd(15'h7FF9, 8'h92, "R10 osc bit readback");

    @(negedge clk);
    bus_addr = 15'h1234; bus_wdata = 8'hAB; bus_wr = 1;
    #1 check("R1 ram_wr", 64'(ram_wr), 1);
    check("R1 ram_addr", 64'(ram_addr), 64'h1234);
    check("R1 ram_wdata", 64'(ram_wdata), 64'hAB);
    @(negedge clk); bus_wr = 0;
    rd(15'h7FF7, 8'hAD, "R2 RAM read at 0x7FF7");
    rd(15'h0000, 8'h5A, "R2 RAM read at 0");

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule